// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block steers an external successive-approximation converter core across a programmable subset of up to eight analog inputs. Software sets a channel mask, picks single-pass or repeating operation, and sets a run bit. The sequencer then visits the enabled channels from the lowest index upward. It issues one conversion request per channel and stores each returned result in that channel's own data register. At the end of every pass it raises an end flag, which can drive an interrupt.

Inputs 0, 1 and 2 form a group that shares one sample instant. When any of them is enabled, the pass opens with a single sample-hold strobe and a fixed offset-cancel interval. The group's channels are then converted one at a time. The end flag is protected against accidental clearing: a zero write only clears it after software has seen it set. A transfer-controller acknowledge clears it directly.

Top module: `adc_scan_seq`

Register map. The register map uses `reg_addr`:
- Address 0 is control. It holds bit 0 run, bit 1 repeat mode, bit 2 interrupt enable and bit 3 end flag.
- Address 1 is the channel mask, with bit n enabling channel n.
- Addresses 8 to 15 hold the result of channel `reg_addr - 8` in bits 11:0.

Read data appears on `reg_rdata` one cycle after `reg_rd`.

## Requirements
- R1: After reset, the control register reads 0, `irq` is low, and `conv_start` and `conv_sample` are low.
- R2: Each pass converts every channel enabled in the mask exactly once, in strictly ascending channel order.
- R3: When a pass contains any of channels 0 to 2, exactly one `conv_sample` pulse is emitted, and the first `conv_start` follows it after exactly 5 cycles (the strobe cycle plus a 4-cycle offset-cancel interval). A pass with none of these channels emits no strobe.
- R4: When a conversion completes, its 12-bit result becomes readable at address 8 plus its channel number.
- R5: With repeat mode 0, completing a pass sets the end flag (control bit 3) and clears the run bit (control bit 0).
- R6: With repeat mode 1, passes repeat back to back and each pass sets the end flag. The run bit stays 1 until software writes it to 0, after which no further conversion starts.
- R7: `irq` is high exactly while the end flag and interrupt enable (control bit 2) are both 1.
- R8: A control write with bit 3 at 0 clears the end flag only if a control read saw the flag at 1 since the flag was last set. Without such a read, the write leaves the flag at 1.
- R9: A one-cycle pulse on `xfer_ack` clears the end flag.
- R10: Clearing the run bit during a pass lets the conversion in progress finish. That result is discarded, the channel's data register keeps its old value, and the end flag is not set.
- R11: Setting the run bit while the mask is all zeros starts no conversion. The run bit reads back 0 afterwards and the end flag stays 0.
- R12: `conv_start` is a one-cycle pulse, with `conv_chan` naming a channel that is enabled for the current pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid one cycle after `reg_rd` |
| xfer_ack | input | 1 | Transfer-controller acknowledge, clears end flag |
| irq | output | 1 | End-of-scan interrupt |
| conv_start | output | 1 | Conversion request pulse to the core |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_sample | output | 1 | Group sample-hold strobe |
| conv_done | input | 1 | Conversion complete pulse from the core |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |

## Verification
On every cycle, the assertions check the handshake shape:
- the request is a single-cycle pulse on an enabled channel;
- the sample strobe is always followed by a gap before any request;
- the end flag rises only on a completed pass, never on an aborted one;
- a run request with an empty mask is dropped the next cycle.

Several properties span whole passes or register accesses, so only the bench scenarios can show them:
- ascending order across randomly drawn masks and converter latencies;
- the exact sample-to-request spacing;
- stored results;
- the read-then-write flag protocol, and the acknowledge clear;
- repeating passes, and the abort that keeps old data.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SAMPLE,
    SEQ_OFFSET,
    SEQ_ISSUE,
    SEQ_WAIT
  } seq_state_e;

  // control register bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_REP  = 1;
  localparam int CTL_IEN  = 2;
  localparam int CTL_FLAG = 3;

endpackage

// File: rtl/adc_lowest_pick.sv
module adc_lowest_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int W   = 12,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH            = 8,
  parameter int RES_W          = 12,
  parameter int OFC_LEN        = 4,
  parameter logic [NCH-1:0] GRP = 'b111,
  localparam int CW            = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int OW            = $clog2(OFC_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [NCH-1:0]   chan_mask,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             conv_start,
  output logic [CW-1:0]    conv_chan,
  output logic             conv_sample,
  output logic             res_we,
  output logic [CW-1:0]    res_wa,
  output logic [RES_W-1:0] res_wd,
  output logic             pass_done,
  output logic             empty_run,
  output logic [NCH-1:0]   pend_mask,
  output logic             seq_idle,
  output logic             seq_wait
);
  seq_state_e     state;
  logic [NCH-1:0] pend, pend_rem, pick_src;
  logic [CW-1:0]  cur, pick_idx;
  logic [OW-1:0]  ofc_cnt;

  always_comb begin
    pend_rem = pend & ~(NCH'(1) << cur);
    case (state)
      SEQ_IDLE: pick_src = chan_mask;
      SEQ_WAIT: pick_src = pend_rem;
      default:  pick_src = pend;
    endcase
  end

  adc_lowest_pick #(.N(NCH)) pick_i (.req(pick_src), .idx(pick_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      pend    <= '0;
      cur     <= '0;
      ofc_cnt <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (run && |chan_mask) begin
          pend <= chan_mask;
          if (|(chan_mask & GRP)) begin
            state <= SEQ_SAMPLE;
          end else begin
            state <= SEQ_ISSUE;
            cur   <= pick_idx;
          end
        end
        SEQ_SAMPLE: begin
          state   <= SEQ_OFFSET;
          ofc_cnt <= '0;
        end
        SEQ_OFFSET: if (ofc_cnt == OW'(OFC_LEN - 1)) begin
          if (!run) begin
            state <= SEQ_IDLE;
          end else begin
            state <= SEQ_ISSUE;
            cur   <= pick_idx;
          end
        end else begin
          ofc_cnt <= ofc_cnt + 1'b1;
        end
        SEQ_ISSUE: state <= SEQ_WAIT;
        SEQ_WAIT: if (conv_done) begin
          if (!run || pend_rem == '0) begin
            state <= SEQ_IDLE;
          end else begin
            state <= SEQ_ISSUE;
            cur   <= pick_idx;
          end
          pend <= pend_rem;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start  = (state == SEQ_ISSUE);
  assign conv_sample = (state == SEQ_SAMPLE);
  assign conv_chan   = cur;
  assign res_we      = (state == SEQ_WAIT) && conv_done && run;
  assign res_wa      = cur;
  assign res_wd      = conv_result;
  assign pass_done   = res_we && (pend_rem == '0);
  assign empty_run   = (state == SEQ_IDLE) && run && (chan_mask == '0);
  assign pend_mask   = pend;
  assign seq_idle    = (state == SEQ_IDLE);
  assign seq_wait    = (state == SEQ_WAIT);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int RES_W   = 12,
  parameter int OFC_LEN = 4,
  parameter int AW      = 4,
  parameter int DW      = 16,
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             xfer_ack,
  output logic             irq,
  output logic             conv_start,
  output logic [CW-1:0]    conv_chan,
  output logic             conv_sample,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result
);
  logic           start_q, mode_q, ie_q, flag_q, armed_q;
  logic [NCH-1:0] mask_q, pend_mask;
  logic           ctrl_wr, mask_wr, ctrl_rd;
  logic           res_we, pass_done, empty_run, seq_idle, seq_wait;
  logic [CW-1:0]  res_wa;
  logic [RES_W-1:0] res_wd, bank_rd;
  logic           rd_bank_q;
  logic [DW-1:0]  rd_reg_q;
  logic           unused_bits;

  assign unused_bits = ^{reg_wdata[DW-1:NCH], reg_addr[AW-2:CW]};

  assign ctrl_wr = reg_wr && (reg_addr == AW'(0));
  assign mask_wr = reg_wr && (reg_addr == AW'(1));
  assign ctrl_rd = reg_rd && (reg_addr == AW'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      mode_q  <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      if ((pass_done && !mode_q) || empty_run) start_q <= 1'b0;
      if (ctrl_wr) begin
        start_q <= reg_wdata[CTL_RUN];
        mode_q  <= reg_wdata[CTL_REP];
        ie_q    <= reg_wdata[CTL_IEN];
      end
      if (mask_wr) mask_q <= reg_wdata[NCH-1:0];
      if (pass_done) begin
        flag_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (xfer_ack) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (ctrl_wr && !reg_wdata[CTL_FLAG] && armed_q) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (ctrl_rd && flag_q) begin
        armed_q <= 1'b1;
      end
    end
  end

  assign irq = flag_q & ie_q;

  adc_scan_ctrl #(
    .NCH(NCH), .RES_W(RES_W), .OFC_LEN(OFC_LEN)
  ) ctrl_i (
    .clk(clk), .rst(rst), .run(start_q), .chan_mask(mask_q),
    .conv_done(conv_done), .conv_result(conv_result),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_sample(conv_sample),
    .res_we(res_we), .res_wa(res_wa), .res_wd(res_wd),
    .pass_done(pass_done), .empty_run(empty_run), .pend_mask(pend_mask),
    .seq_idle(seq_idle), .seq_wait(seq_wait)
  );

  adc_result_bank #(.NCH(NCH), .W(RES_W)) bank_i (
    .clk(clk), .we(res_we), .wa(res_wa), .wd(res_wd),
    .ra(reg_addr[CW-1:0]), .rd(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank_q <= 1'b0;
      rd_reg_q  <= '0;
    end else if (reg_rd) begin
      rd_bank_q <= reg_addr[AW-1];
      if (reg_addr == AW'(0))
        rd_reg_q <= {{(DW-4){1'b0}}, flag_q, ie_q, mode_q, start_q};
      else if (reg_addr == AW'(1))
        rd_reg_q <= {{(DW-NCH){1'b0}}, mask_q};
      else
        rd_reg_q <= '0;
    end
  end

  assign reg_rdata = rd_bank_q ? {{(DW-RES_W){1'b0}}, bank_rd} : rd_reg_q;
endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
  parameter int NCH = 8,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst,
  input logic           conv_start,
  input logic           conv_sample,
  input logic [CW-1:0]  conv_chan,
  input logic           conv_done,
  input logic [NCH-1:0] pass_mask,
  input logic           flag,
  input logic           start,
  input logic [NCH-1:0] mask,
  input logic           ctrl_wr,
  input logic           pass_done,
  input logic           seq_idle,
  input logic           seq_wait
);
  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  assert_chan_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> pass_mask[conv_chan]);

  assert_sample_gap_R3: assert property (@(posedge clk) disable iff (rst)
    conv_sample |=> (!conv_start && !conv_sample));

  assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(pass_done));

  assert_abort_noflag_R10: assert property (@(posedge clk) disable iff (rst)
    (seq_wait && conv_done && !start) |=> !$rose(flag));

  assert_empty_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && start && mask == '0 && !ctrl_wr) |=> !start);
endmodule

bind adc_scan_seq adc_scan_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_sample(conv_sample),
  .conv_chan(conv_chan), .conv_done(conv_done), .pass_mask(pend_mask),
  .flag(flag_q), .start(start_q), .mask(mask_q), .ctrl_wr(ctrl_wr),
  .pass_done(pass_done), .seq_idle(seq_idle), .seq_wait(seq_wait)
);

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xfer_ack = 1'b0;
  logic        irq, conv_start, conv_sample;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;

  int checks = 0, errors = 0;
  int cyc = 0, lat = 2, seqn = 1;
  int n_sample = 0, sample_cyc = -1, first_start = -1;
  int log_ch[$];
  logic [11:0] exp_data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_ack(xfer_ack), .irq(irq),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_sample(conv_sample),
    .conv_done(conv_done), .conv_result(conv_result)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (conv_sample) begin
      n_sample   <= n_sample + 1;
      sample_cyc <= cyc;
    end
  end

  // converter core model
  initial begin
    forever begin
      @(negedge clk);
      while (conv_start) begin
        automatic int ch = int'(conv_chan);
        log_ch.push_back(ch);
        if (first_start < 0) first_start = cyc;
        repeat (lat) @(negedge clk);
        conv_result = {ch[2:0], seqn[8:0]};
        exp_data[ch] = conv_result;
        seqn++;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  function automatic int popc(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic bit order_ok(input logic [7:0] m, input int base);
    int k = base;
    for (int i = 0; i < 8; i++) begin
      if (m[i]) begin
        if (k >= log_ch.size() || log_ch[k] != i) return 1'b0;
        k++;
      end
    end
    return 1'b1;
  endfunction

  task automatic clear_log();
    log_ch.delete();
    n_sample = 0; sample_cyc = -1; first_start = -1;
  endtask

  task automatic wait_convs(input int n);
    while (log_ch.size() < n) @(negedge clk);
    repeat (lat + 4) @(negedge clk);
  endtask

  task automatic run_single(input logic [7:0] m, input bit ie);
    clear_log();
    wr(4'd1, {8'h0, m});
    wr(4'd0, {13'h0, ie, 1'b0, 1'b1});
    wait_convs(popc(m));
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    rd(4'd0, v);
    check(v == 16'h0 && !irq && !conv_start && !conv_sample, "R1 reset state", v, 0);

    // empty mask
    clear_log();
    wr(4'd1, 16'h0);
    wr(4'd0, 16'h0001);
    repeat (4) @(negedge clk);
    rd(4'd0, v);
    check(v[0] == 1'b0 && v[3] == 1'b0, "R11 empty mask run/flag", v, 0);
    check(log_ch.size() == 0 && n_sample == 0, "R11 no conversion", log_ch.size(), 0);

    // random single passes
    for (int p = 0; p < 16; p++) begin
      automatic logic [7:0] m = 8'(($urandom % 255) + 1);
      automatic bit ie = 1'($urandom % 2);
      automatic bit okd = 1'b1;
      lat = 1 + int'($urandom % 4);
      run_single(m, ie);
      check(log_ch.size() == popc(m) && order_ok(m, 0), "R2 ascending order", log_ch.size(), popc(m));
      if (|m[2:0]) begin
        check(n_sample == 1, "R3 one sample strobe", n_sample, 1);
        check(first_start - sample_cyc == 5, "R3 offset-cancel gap", first_start - sample_cyc, 5);
      end else begin
        check(n_sample == 0, "R3 no strobe without group", n_sample, 0);
      end
      check(irq == ie, "R7 irq follows enable", irq, ie);
      rd(4'd0, v);
      check(v[3] == 1'b1 && v[0] == 1'b0, "R5 flag set run cleared", v, 16'h8);
      for (int c = 0; c < 8; c++) begin
        if (m[c]) begin
          rd(4'(8 + c), v);
          if (v[11:0] != exp_data[c]) okd = 1'b0;
        end
      end
      check(okd, "R4 stored results", m, m);
      wr(4'd0, 16'h0);
      rd(4'd0, v);
      check(v[3] == 1'b0 && !irq, "R8 read then write zero clears", v, 0);
    end

    // write zero without prior read
    lat = 2;
    run_single(8'h10, 1'b1);
    wr(4'd0, 16'h0004);
    rd(4'd0, v);
    check(v[3] == 1'b1 && irq, "R8 blind zero write ignored", v, 16'hC);
    wr(4'd0, 16'h0004);
    rd(4'd0, v);
    check(v[3] == 1'b0 && !irq, "R8 clear after read", v, 16'h4);

    // transfer acknowledge
    run_single(8'h20, 1'b1);
    check(irq == 1'b1, "R7 irq raised", irq, 1);
    xfer_ack = 1'b1;
    @(negedge clk);
    xfer_ack = 1'b0;
    check(!irq, "R9 ack drops irq", irq, 0);
    rd(4'd0, v);
    check(v[3] == 1'b0, "R9 ack clears flag", v, 0);

    // continuous mode
    clear_log();
    lat = 3;
    wr(4'd1, 16'h000C);
    wr(4'd0, 16'h0003);
    wait_convs(4);
    check(order_ok(8'h0C, 0) && order_ok(8'h0C, 2), "R6 repeated ascending passes", log_ch.size(), 4);
    check(n_sample >= 2, "R6 strobe per pass", n_sample, 2);
    rd(4'd0, v);
    check(v[3] == 1'b1 && v[0] == 1'b1, "R6 flag set run held", v, 16'hB);
    wr(4'd0, 16'h000A);
    repeat (12) @(negedge clk);
    clear_log();
    repeat (30) @(negedge clk);
    check(log_ch.size() == 0, "R6 stop after run cleared", log_ch.size(), 0);
    rd(4'd0, v);
    check(v[0] == 1'b0, "R6 run reads 0", v, 0);
    wr(4'd0, 16'h0);

    // abort mid-pass
    lat = 2;
    run_single(8'h80, 1'b0);
    rd(4'd0, v);
    wr(4'd0, 16'h0);
    begin
      automatic logic [11:0] old = exp_data[7];
      clear_log();
      lat = 6;
      wr(4'd0, 16'h0001);
      while (log_ch.size() < 1) @(negedge clk);
      wr(4'd0, 16'h0000);
      repeat (12) @(negedge clk);
      rd(4'd0, v);
      check(v[3] == 1'b0 && v[0] == 1'b0, "R10 abort no flag", v, 0);
      rd(4'd15, v);
      check(v[11:0] == old, "R10 abort keeps old data", v[11:0], old);
      exp_data[7] = old;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule